// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is a 12-pin general-purpose I/O port on a single-cycle memory-mapped register bus. It decodes a word-aligned byte offset. Inside the data window, address bits [13:2] form a per-pin access mask. Software can therefore drive or sample any subset of pins with one store or one load, with no read-modify-write. Each of the 4096 word aliases of the data register selects its own pin subset.

Next to the data window sit three control registers: a direction register, a per-pin edge interrupt enable and a write-only interrupt clear. The interrupt clear register always reads back as 0. Each input pin passes through a two-flop synchronizer. A rising edge on an enabled pin sets that pin's edge latch. The OR of the enabled latches reaches the interrupt output through a two-stage synchronizer.

Byte offsets are 16 bits wide. Offsets 0x0000 to 0x3FFC form the data window. Offset 0x4000 is the direction register, 0x4004 the interrupt enable and 0x4008 the interrupt clear. Any other offset reads 0 and ignores writes.

Top module: `gpio_mask_port`

## Requirements
- R1: After the synchronous active-low reset, `pinOut`, `pinOe` and `irqOut` are 0, the direction register reads 0, and a full-mask data read with all pins low returns 0.
- R2: A data write updates pin bit i only when offset bit (i+2) is 1. Every other bit keeps its value, and a write at offset 0x0000 changes nothing.
- R3: At data offset 0x3FFC all 12 mask bits are set, so a write there loads all 12 bits and a read there returns all 12 bits.
- R4: A data read returns 0 in every bit whose mask bit (offset bit i+2) is 0.
- R5: At offset 0x098 the mask covers pins 1, 2 and 5 only. Writing 0xFE4 there drives pins 2 and 5 to 1 and pin 1 to 0, and leaves all other pins unchanged.
- R6: In the direction register (offset 0x4000), bit i = 1 makes pin i an output and drives `pinOe[i]`. A data read returns the output register bit for output pins and the synchronized pin level for input pins.
- R7: A rising edge on synchronized input i sets that pin's edge latch only if interrupt enable bit i (offset 0x4004) is 1. `irqOut` is the OR of the enabled latches, delayed by two flops. Edges seen while the pin is disabled are lost.
- R8: Writing 1 to bit i of the clear register (offset 0x4008) clears latch i, and `irqOut` falls two clocks after the write's clock edge. Writing 0 to a bit has no effect.
- R9: If a clear and a rising-edge set hit the same latch in the same cycle, the clear wins and the latch stays 0.
- R10: The clear register is write-only and always reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busValid | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 16 | Byte offset of the access |
| busWdata | input | 32 | Write data; bits above 11 ignored |
| busRdata | output | 32 | Read data, valid in the same cycle as a read |
| pinIn | input | 12 | Pin levels, asynchronous |
| pinOut | output | 12 | Output data register |
| pinOe | output | 12 | Output enable per pin (direction) |
| irqOut | output | 1 | Synchronized edge interrupt |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as a rising-edge set on the same pin (R9). To get there, the stimulus raises the pin just before one clock edge and counts the two synchronizer stages. It then issues the clear so that the bus sees it at the third edge, which is exactly when the latch would otherwise set. The masked-write vectors start from a value that differs from the written data in every masked bit, so an unmasked leak or a lost update shows in the full-mask readback.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  // Control register index (byte offset bits [3:2] in the control window)
  localparam logic [1:0] REG_DIR = 2'd0;
  localparam logic [1:0] REG_IEN = 2'd1;
  localparam logic [1:0] REG_CLR = 2'd2;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_IEN  = 2'd2,
    SEL_ZERO = 2'd3
  } readSelT;

  typedef struct packed {
    logic dataWr;
    logic dirWr;
    logic ienWr;
    logic clrWr;
  } ctrlStrobesT;

endpackage

// File: rtl/gpio_bus_ctrl.sv
module gpio_bus_ctrl
  import gpio_mask_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 12,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [PIN_COUNT-1:0] dataRead,
  input  logic [PIN_COUNT-1:0] dirQ,
  input  logic [PIN_COUNT-1:0] ienQ,
  output ctrlStrobesT          strb,
  output logic [PIN_COUNT-1:0] accMask,
  output logic [DATA_W-1:0]    busRdata
);

  localparam int unsigned MASK_LO = 2;
  localparam int unsigned MASK_HI = PIN_COUNT + 1;
  localparam int unsigned WIN_LSB = PIN_COUNT + 2;
  localparam int unsigned WIN_W   = ADDR_W - WIN_LSB;

  logic [WIN_W-1:0] window;
  logic             inData;
  logic             inCtrl;
  logic [1:0]       regIdx;
  logic             ctrlLowZero;
  readSelT          rdSel;
  logic             unusedAddrBits;

  assign window         = busAddr[ADDR_W-1:WIN_LSB];
  assign inData         = (window == '0);
  assign regIdx         = busAddr[3:2];
  assign ctrlLowZero    = (busAddr[MASK_HI:4] == '0);
  assign inCtrl         = (window == WIN_W'(1)) && ctrlLowZero;
  assign accMask        = busAddr[MASK_HI:MASK_LO];
  assign unusedAddrBits = ^busAddr[1:0];

  always_comb begin
    strb = '0;
    if (busValid && busWrite) begin
      strb.dataWr = inData;
      strb.dirWr  = inCtrl && (regIdx == REG_DIR);
      strb.ienWr  = inCtrl && (regIdx == REG_IEN);
      strb.clrWr  = inCtrl && (regIdx == REG_CLR);
    end
  end

  always_comb begin
    rdSel = SEL_ZERO;
    if (inData)                           rdSel = SEL_DATA;
    else if (inCtrl && regIdx == REG_DIR) rdSel = SEL_DIR;
    else if (inCtrl && regIdx == REG_IEN) rdSel = SEL_IEN;
  end

  always_comb begin
    busRdata = '0;
    if (busValid && !busWrite) begin
      unique case (rdSel)
        SEL_DATA: busRdata = DATA_W'(dataRead);
        SEL_DIR:  busRdata = DATA_W'(dirQ);
        SEL_IEN:  busRdata = DATA_W'(ienQ);
        default:  busRdata = '0;
      endcase
    end
  end

  // R10: the clear register never returns data
  assert_clr_reads_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && inCtrl && regIdx == REG_CLR) |-> (busRdata == '0));

  // At most one register is written per access
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.dataWr, strb.dirWr, strb.ienWr, strb.clrWr}));

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_mask_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobesT          strb,
  input  logic [PIN_COUNT-1:0] accMask,
  input  logic [PIN_COUNT-1:0] wdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] dataRead,
  output logic [PIN_COUNT-1:0] dirQ,
  output logic [PIN_COUNT-1:0] ienQ,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);

  logic [PIN_COUNT-1:0] dataOutQ;
  logic [PIN_COUNT-1:0] syncA;
  logic [PIN_COUNT-1:0] syncB;
  logic [PIN_COUNT-1:0] prevQ;
  logic [PIN_COUNT-1:0] riseHit;
  logic [PIN_COUNT-1:0] clrVec;
  logic [PIN_COUNT-1:0] latchQ;
  logic [PIN_COUNT-1:0] pinVal;
  logic                 irqRaw;
  logic                 irqS1;
  logic                 irqS2;

  // Masked output data register
  always_ff @(posedge clk) begin
    if (!rstN)            dataOutQ <= '0;
    else if (strb.dataWr) dataOutQ <= (dataOutQ & ~accMask) | (wdata & accMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ <= '0;
      ienQ <= '0;
    end else begin
      if (strb.dirWr) dirQ <= wdata;
      if (strb.ienWr) ienQ <= wdata;
    end
  end

  // Input synchronizer plus one delay stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  assign riseHit = syncB & ~prevQ & ienQ;
  assign clrVec  = strb.clrWr ? wdata : '0;

  for (genvar g = 0; g < PIN_COUNT; g++) begin : g_edge
    logic bitQ;
    always_ff @(posedge clk) begin
      if (!rstN)           bitQ <= 1'b0;
      else if (clrVec[g])  bitQ <= 1'b0;
      else if (riseHit[g]) bitQ <= 1'b1;
    end
    assign latchQ[g] = bitQ;
  end

  assign irqRaw = |(latchQ & ienQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqS1 <= 1'b0;
      irqS2 <= 1'b0;
    end else begin
      irqS1 <= irqRaw;
      irqS2 <= irqS1;
    end
  end

  assign pinVal   = (dirQ & dataOutQ) | (~dirQ & syncB);
  assign dataRead = pinVal & accMask;
  assign pinOut   = dataOutQ;
  assign pinOe    = dirQ;
  assign irqOut   = irqS2;

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataWr |=> (((dataOutQ ^ $past(dataOutQ)) & ~$past(accMask)) == '0));

  assert_full_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && (&accMask)) |=> (dataOutQ == $past(wdata)));

  assert_need_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((latchQ & ~$past(latchQ)) & ~$past(ienQ)) == '0));

  assert_irq_delay_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ##1 (irqOut == $past(irqRaw, 2)));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrWr |=> ((latchQ & $past(wdata)) == '0));

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 12,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);

  ctrlStrobesT          strb;
  logic [PIN_COUNT-1:0] accMask;
  logic [PIN_COUNT-1:0] dataRead;
  logic [PIN_COUNT-1:0] dirQ;
  logic [PIN_COUNT-1:0] ienQ;
  logic                 unusedWdataBits;

  assign unusedWdataBits = ^busWdata[DATA_W-1:PIN_COUNT];

  gpio_bus_ctrl #(
    .PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .dataRead(dataRead), .dirQ(dirQ), .ienQ(ienQ),
    .strb(strb), .accMask(accMask), .busRdata(busRdata)
  );

  gpio_port_datapath #(
    .PIN_COUNT(PIN_COUNT)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .accMask(accMask), .wdata(busWdata[PIN_COUNT-1:0]),
    .pinIn(pinIn),
    .dataRead(dataRead), .dirQ(dirQ), .ienQ(ienQ),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

endmodule

// File: tb/sim_gpio_mask_port.sv
module sim_gpio_mask_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [11:0] pinIn = '0;
  logic [11:0] pinOut;
  logic [11:0] pinOe;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_mask_port u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [15:0] wrAddr;
    logic [11:0] wrData;
    logic [15:0] rdAddr;
    logic [11:0] expRd;
  } vecT;

  // Sequence of masked writes, each followed by one masked read
  localparam vecT VEC [0:5] = '{
    '{16'h3FFC, 12'h0C3, 16'h3FFC, 12'h0C3},  // R3 full write
    '{16'h0098, 12'hFE4, 16'h3FFC, 12'h0E5},  // R5 pins 1,2,5
    '{16'h0004, 12'h000, 16'h3FFC, 12'h0E4},  // R2 pin 0 only
    '{16'h2000, 12'hFFF, 16'h2000, 12'h800},  // R4 pin 11 only
    '{16'h0000, 12'hFFF, 16'h3FFC, 12'h8E4},  // R2 empty mask
    '{16'h1554, 12'h000, 16'h0098, 12'h020}   // R4 partial read
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pinOut", 32'(pinOut), 32'h0);
    check("R1 pinOe", 32'(pinOe), 32'h0);
    check("R1 irqOut", 32'(irqOut), 32'h0);
    busRd(16'h4000, rd); check("R1 dir read", rd, 32'h0);
    busRd(16'h3FFC, rd); check("R1 data read", rd, 32'h0);

    // All pins outputs, then walk the vector table
    busWr(16'h4000, 32'hFFF);
    for (int i = 0; i < 6; i++) begin
      busWr(VEC[i].wrAddr, 32'(VEC[i].wrData));
      busRd(VEC[i].rdAddr, rd);
      check($sformatf("R2/R3/R4/R5 vector %0d", i), rd, 32'(VEC[i].expRd));
    end
    check("R2 pinOut after table", 32'(pinOut), 32'h8A0);

    // R6 direction: low nibble outputs, rest inputs
    busWr(16'h4000, 32'h00F);
    pinIn = 12'hAA0;
    waitCyc(4);
    check("R6 pinOe", 32'(pinOe), 32'h00F);
    check("R6 pinOut held", 32'(pinOut), 32'h8A0);
    busRd(16'h3FFC, rd); check("R6 mixed read", rd, 32'hAA0);
    check("R7 disabled edges", 32'(irqOut), 32'h0);

    // R7 enabling after the edge does not recover it
    busWr(16'h4004, 32'h001);
    waitCyc(4);
    check("R7 late enable", 32'(irqOut), 32'h0);
    busRd(16'h4004, rd); check("R7 enable readback", rd, 32'h001);

    // R7 enabled rising edge on pin 0
    pinIn = 12'hAA1;
    waitCyc(6);
    check("R7 edge sets irq", 32'(irqOut), 32'h1);

    // R8 clear with zeros has no effect; R10 read of clear register
    busWr(16'h4008, 32'h000);
    waitCyc(4);
    check("R8 zero clear", 32'(irqOut), 32'h1);
    busRd(16'h4008, rd); check("R10 clear reads zero", rd, 32'h0);

    // R8 clear timing: write sampled at edge k, irqOut low after k+2
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 16'h4008; busWdata = 32'h001;
    @(negedge clk);  // after edge k
    busValid = 1'b0; busWrite = 1'b0;
    check("R8 still high k", 32'(irqOut), 32'h1);
    @(negedge clk);  // after k+1
    check("R8 still high k+1", 32'(irqOut), 32'h1);
    @(negedge clk);  // after k+2
    check("R8 low k+2", 32'(irqOut), 32'h0);

    // R9 clear coincides with the set request
    pinIn = 12'hAA0;
    waitCyc(5);
    pinIn = 12'hAA1;          // edge A: syncA
    @(negedge clk);           // edge B: syncB, set request pending
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 16'h4008; busWdata = 32'h001;
    @(negedge clk);           // edge C: clear and set together
    busValid = 1'b0; busWrite = 1'b0;
    waitCyc(5);
    check("R9 clear wins", 32'(irqOut), 32'h0);

    // R7 a fresh edge without a clear sets it again
    pinIn = 12'hAA0;
    waitCyc(4);
    pinIn = 12'hAA1;
    waitCyc(6);
    check("R7 fresh edge", 32'(irqOut), 32'h1);

    done = 1'b1;
    finishRun();
  end

endmodule